// File: doc/BRIEF.md
# Serial Key Data Readout Port

This block sits between a key-matrix scanner and a host processor. The scanner offers a 24-bit key image with a one-cycle valid strobe. The block keeps that image until the host has read it. The host sees everything through three signals: an active-low select, a serial clock, and one data line. While the select is inactive, the data line carries a request flag that tells the host an image is waiting. While the select is active, the line carries the image one bit per serial clock, with one dummy bit in front and one behind. Each new bit appears after a falling serial-clock edge, so the host samples on the rising edge.

The select and the serial clock arrive asynchronously. Each passes through a two-flop synchroniser, and its edges are detected in the system clock domain, so the serial clock must run at no more than a quarter of the system clock rate. When the select returns high, the stored image is always released. If the image was read only in part, the captured keys are discarded. In either case the block re-arms and tells the scanner through `scan_en_o` that a new image may be offered. A read started with no request pending returns zeros, and `data_valid_o` is held low for as long as that read lasts.

The controller has four states. `KP_IDLE` is armed, with no request. `KP_PEND` means an image is held and the flag is raised. `KP_READ` means the select is low and the image is shifting. `KP_BLIND` means the select is low but no request was pending.

Its transitions are:
- **accept**: `KP_IDLE` to `KP_PEND` when a key strobe arrives with no select fall in the same cycle.
- **open**: `KP_PEND` to `KP_READ` on a select fall.
- **blind open**: `KP_IDLE` to `KP_BLIND` on a select fall.
- **release**: `KP_READ` to `KP_IDLE` on a select rise. This one drops the image.
- **blind close**: `KP_BLIND` to `KP_IDLE` on a select rise.

Top module: `keydata_shift_port`

## Requirements
- R1: While the select is high, `data_o` is 1 exactly when a key image is waiting, and 0 otherwise.
- R2: `key_valid_i` latches `key_image_i` only while `scan_en_o` is 1. After latching, `scan_en_o` drops to 0. A strobe that arrives while a request is pending, or while the select is low, leaves the stored image unchanged and does not raise the flag.
- R3: After the select falls with a request pending, `data_o` shows a leading dummy 0. Each falling serial-clock edge then moves it on to KD1, KD2 and so on up to KD24, where KDn is `key_image_i[n-1]`. After KD24 comes a trailing dummy 0, which stays for any further edges.
- R4: The framing does not depend on the serial-clock level when the select falls. The first falling edge after the fall always presents KD1. With the clock low at the fall, the host's first rising edge samples the leading dummy.
- R5: A change on `cs_n_i` or `sclk_i` that falls between two system clock edges reaches `data_o` just after the third rising edge that follows it.
- R6: If the select rises after KD24 has been presented, `done_o` pulses for exactly one cycle. The request clears, `data_o` returns to 0, and `scan_en_o` returns to 1.
- R7: If the select rises before KD24, there is no `done_o` pulse. The image is discarded, the request clears and the block re-arms. A following read with no new strobe is an invalid read.
- R8: A select fall with no request pending keeps `data_valid_o` at 0 and `data_o` at 0 for the whole low period. It gives no `done_o` pulse, and `scan_en_o` stays 0 for that period.
- R9: After reset, `data_o` is 0, `data_valid_o` is 1, `scan_en_o` is 1 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host select, active low, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| key_valid_i | input | 1 | One-cycle strobe from the scanner: image ready |
| key_image_i | input | KEYS | Key image; bit n-1 is KDn |
| data_o | output | 1 | Request flag (select high) or shifted key bit (select low) |
| data_valid_o | output | 1 | Low during a read that had no request |
| scan_en_o | output | 1 | Block is armed and will accept a new image |
| done_o | output | 1 | One-cycle pulse when a complete read is closed |

## Verification
The most likely internal faults show up on `data_o` within three system clocks of the serial-clock or select edge that exposes them. A bit position that is off by one shifts the whole recovered image and moves the trailing dummy. A select rise that fails to release the image leaves the flag high. A state stuck in the wrong variant either drives zeros where key data belongs or drops `data_valid_o`. A completion flag that is set too early or too late is seen in the `done_o` pulse count, which is compared against aborted and full reads.

// File: rtl/keyport_pkg.sv
package keyport_pkg;

    typedef enum logic [1:0] {
        KP_IDLE  = 2'd0,
        KP_PEND  = 2'd1,
        KP_READ  = 2'd2,
        KP_BLIND = 2'd3
    } kp_state_e;

    function automatic int pos_width(input int keys);
        return $clog2(keys + 2);
    endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
                prev_q <= RST_VAL[g];
            end else begin
                meta_q <= async_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign rise_o[g] = sync_q & ~prev_q;
        assign fall_o[g] = prev_q & ~sync_q;
    end

endmodule

// File: rtl/kp_bit_counter.sv
module kp_bit_counter #(
    parameter int KEYS = 24,
    localparam int PW   = keyport_pkg::pos_width(KEYS),
    localparam int LAST = KEYS + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [PW-1:0] pos_o,
    output logic          full_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_o <= '0;
        end else if (clear_i) begin
            pos_o <= '0;
        end else if (step_i && (pos_o < PW'(LAST))) begin
            pos_o <= pos_o + 1'b1;
        end
    end

    assign full_o = (pos_o >= PW'(KEYS));

    // R3: each serial falling edge moves exactly one bit position
    assert_pos_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && step_i && (pos_o < PW'(LAST))) |=> (pos_o == $past(pos_o) + 1'b1));

    // R3: no edge, no movement
    assert_pos_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(pos_o));

endmodule

// File: rtl/kp_key_store.sv
module kp_key_store #(
    parameter int KEYS = 24,
    localparam int PW = keyport_pkg::pos_width(KEYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            drop_i,
    input  logic [KEYS-1:0] image_i,
    input  logic [PW-1:0]   pos_i,
    output logic [KEYS-1:0] image_o,
    output logic            bit_o
);

    logic [KEYS-1:0] image_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            image_q <= '0;
        end else if (drop_i) begin
            image_q <= '0;
        end else if (load_i) begin
            image_q <= image_i;
        end
    end

    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < KEYS; i++) begin
            if (pos_i == PW'(i + 1)) begin
                bit_o = image_q[i];
            end
        end
    end

    assign image_o = image_q;

endmodule

// File: rtl/kp_ctrl.sv
module kp_ctrl
    import keyport_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_fall_i,
    input  logic      cs_rise_i,
    input  logic      sclk_fall_i,
    input  logic      key_valid_i,
    input  logic      full_i,
    input  logic      key_bit_i,
    output kp_state_e state_o,
    output logic      accept_o,
    output logic      drop_o,
    output logic      clear_o,
    output logic      step_o,
    output logic      data_o,
    output logic      valid_o,
    output logic      scan_en_o,
    output logic      done_o
);

    kp_state_e state_q;
    kp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        drop_o   = 1'b0;
        unique case (state_q)
            KP_IDLE: begin
                if (cs_fall_i) begin
                    state_d = KP_BLIND;
                end else if (key_valid_i) begin
                    accept_o = 1'b1;
                    state_d  = KP_PEND;
                end
            end
            KP_PEND: begin
                if (cs_fall_i) begin
                    state_d = KP_READ;
                end
            end
            KP_READ: begin
                if (cs_rise_i) begin
                    drop_o  = 1'b1;
                    state_d = KP_IDLE;
                end
            end
            KP_BLIND: begin
                if (cs_rise_i) begin
                    state_d = KP_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        data_o    = 1'b0;
        valid_o   = 1'b1;
        scan_en_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            KP_IDLE:  scan_en_o = 1'b1;
            KP_PEND:  data_o    = 1'b1;
            KP_READ: begin
                data_o = key_bit_i;
                done_o = cs_rise_i & full_i;
            end
            KP_BLIND: valid_o = 1'b0;
        endcase
    end

    assign clear_o = cs_fall_i;
    assign step_o  = (state_q == KP_READ) & sclk_fall_i;
    assign state_o = state_q;

    // R6: completion is reported in one cycle only
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/keydata_shift_port.sv
module keydata_shift_port
    import keyport_pkg::*;
#(
    parameter int KEYS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n_i,
    input  logic            sclk_i,
    input  logic            key_valid_i,
    input  logic [KEYS-1:0] key_image_i,
    output logic            data_o,
    output logic            data_valid_o,
    output logic            scan_en_o,
    output logic            done_o
);

    localparam int PW = pos_width(KEYS);

    logic [1:0]      edge_rise;
    logic [1:0]      edge_fall;
    logic            cs_fall;
    logic            cs_rise;
    logic            sclk_fall;
    logic [PW-1:0]   pos;
    logic            full;
    logic            key_bit;
    logic [KEYS-1:0] image;
    kp_state_e       state;
    logic            accept;
    logic            drop;
    logic            clear;
    logic            step;

    kp_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, cs_n_i}),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    assign cs_fall   = edge_fall[0];
    assign cs_rise   = edge_rise[0];
    assign sclk_fall = edge_fall[1];

    kp_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .sclk_fall_i (sclk_fall),
        .key_valid_i (key_valid_i),
        .full_i      (full),
        .key_bit_i   (key_bit),
        .state_o     (state),
        .accept_o    (accept),
        .drop_o      (drop),
        .clear_o     (clear),
        .step_o      (step),
        .data_o      (data_o),
        .valid_o     (data_valid_o),
        .scan_en_o   (scan_en_o),
        .done_o      (done_o)
    );

    kp_bit_counter #(.KEYS(KEYS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .step_i  (step),
        .pos_o   (pos),
        .full_o  (full)
    );

    kp_key_store #(.KEYS(KEYS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .drop_i  (drop),
        .image_i (key_image_i),
        .pos_i   (pos),
        .image_o (image),
        .bit_o   (key_bit)
    );

    // R2: an accepted image raises the flag and disarms the scanner
    assert_accept_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (data_o && !scan_en_o));

    // R2: a held image is never overwritten
    assert_hold_image_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KP_PEND) |=> $stable(image));

    // R6, R7: closing a read empties the store and re-arms
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ((image == '0) && scan_en_o && !data_o));

    // R8: a read opened with no request is marked invalid
    assert_blind_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == KP_IDLE) && cs_fall) |=> (!data_valid_o && !data_o));

endmodule

// File: tb/keydata_shift_port_test.sv
module keydata_shift_port_test;

    localparam int KEYS = 24;
    localparam int HALF = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n_i = 1'b1;
    logic            sclk_i = 1'b0;
    logic            key_valid_i = 1'b0;
    logic [KEYS-1:0] key_image_i = '0;
    logic            data_o;
    logic            data_valid_o;
    logic            scan_en_o;
    logic            done_o;

    int    checks = 0;
    int    errors = 0;
    int    done_cnt = 0;
    bit    finished = 0;
    string cur_req = "R9";
    logic  sampled;
    logic [KEYS-1:0] got;

    always #2 clk = ~clk;

    keydata_shift_port #(.KEYS(KEYS)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (cs_n_i),
        .sclk_i       (sclk_i),
        .key_valid_i  (key_valid_i),
        .key_image_i  (key_image_i),
        .data_o       (data_o),
        .data_valid_o (data_valid_o),
        .scan_en_o    (scan_en_o),
        .done_o       (done_o)
    );

    // reference model: 0 idle, 1 waiting, 2 reading, 3 read without request
    int              m_state;
    int              m_pos;
    logic [KEYS-1:0] m_key;
    logic            c0, c1, c2, k0, k1, k2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_pos = 0; m_key = '0;
            c0 = 1; c1 = 1; c2 = 1; k0 = 0; k1 = 0; k2 = 0;
        end else begin
            bit cfall, crise, sfall;
            cfall = c2 && !c1;
            crise = !c2 && c1;
            sfall = k2 && !k1;
            if (cfall) m_pos = 0;
            case (m_state)
                0: if (cfall) m_state = 3;
                   else if (key_valid_i) begin m_state = 1; m_key = key_image_i; end
                1: if (cfall) m_state = 2;
                2: if (crise) begin m_state = 0; m_key = '0; end
                   else if (sfall && m_pos < KEYS + 1) m_pos++;
                default: if (crise) m_state = 0;
            endcase
            c2 = c1; c1 = c0; c0 = cs_n_i;
            k2 = k1; k1 = k0; k0 = sclk_i;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic e_data, e_valid, e_scan, e_done;
            e_data  = (m_state == 1) ||
                      (m_state == 2 && m_pos >= 1 && m_pos <= KEYS && m_key[m_pos - 1]);
            e_valid = (m_state != 3);
            e_scan  = (m_state == 0);
            e_done  = (m_state == 2) && !c2 && c1 && (m_pos >= KEYS);
            checks++;
            if ({data_o, data_valid_o, scan_en_o, done_o} !== {e_data, e_valid, e_scan, e_done}) begin
                errors++;
                $display("FAIL %s model compare: data/valid/scan/done actual %b%b%b%b expected %b%b%b%b",
                         cur_req, data_o, data_valid_o, scan_en_o, done_o,
                         e_data, e_valid, e_scan, e_done);
            end
            if (done_o) done_cnt++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic offer(input logic [KEYS-1:0] img);
        key_image_i = img; key_valid_i = 1'b1;
        @(negedge clk);
        key_valid_i = 1'b0;
    endtask

    task automatic rise_sample();
        sampled = data_o;
        sclk_i = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic fall_edge();
        sclk_i = 1'b0;
        wait_cyc(HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        check("R9 data after reset", data_o, 0);
        check("R9 valid after reset", data_valid_o, 1);
        check("R9 scan_en after reset", scan_en_o, 1);
        check("R9 done after reset", done_o, 0);

        cur_req = "R1";
        wait_cyc(5);
        check("R1 flag idle", data_o, 0);
        offer(24'hA5_3C_81);
        check("R1 flag raised", data_o, 1);
        check("R2 scan_en dropped", scan_en_o, 0);

        cur_req = "R2";
        offer(24'h12_34_56);
        wait_cyc(3);

        cur_req = "R5";
        sclk_i = 1'b1;
        wait_cyc(HALF);
        cs_n_i = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R5 flag held two edges", data_o, 1);
        @(posedge clk); @(negedge clk);
        check("R5 dummy after third edge", data_o, 0);
        check("R5 valid during read", data_valid_o, 1);
        wait_cyc(HALF);

        cur_req = "R3";
        for (int i = 0; i < KEYS; i++) begin
            fall_edge();
            rise_sample();
            got[i] = sampled;
        end
        check("R3 image clock high at select fall", got, 24'hA5_3C_81);
        fall_edge(); rise_sample();
        check("R3 trailing dummy", sampled, 0);
        fall_edge(); rise_sample();
        check("R3 dummy stays", sampled, 0);
        cur_req = "R6";
        cs_n_i = 1'b1;
        wait_cyc(HALF);
        check("R6 done pulse count", done_cnt, 1);
        check("R6 flag cleared", data_o, 0);
        check("R6 re-armed", scan_en_o, 1);

        cur_req = "R4";
        sclk_i = 1'b0;
        wait_cyc(HALF);
        offer(24'h0F_F0_5A);
        cs_n_i = 1'b0;
        wait_cyc(HALF);
        rise_sample();
        check("R4 leading dummy with clock low", sampled, 0);
        for (int i = 0; i < KEYS; i++) begin
            fall_edge();
            rise_sample();
            got[i] = sampled;
        end
        check("R4 image clock low at select fall", got, 24'h0F_F0_5A);
        fall_edge();
        cs_n_i = 1'b1;
        wait_cyc(HALF);
        check("R6 second done pulse", done_cnt, 2);

        cur_req = "R7";
        sclk_i = 1'b1;
        wait_cyc(HALF);
        offer(24'hC3_96_E7);
        cs_n_i = 1'b0;
        wait_cyc(HALF);
        for (int i = 0; i < 10; i++) begin
            fall_edge();
            rise_sample();
            got[i] = sampled;
        end
        check("R3 partial bits", got[9:0], 10'h2E7);
        cs_n_i = 1'b1;
        wait_cyc(HALF);
        check("R7 no done on abort", done_cnt, 2);
        check("R7 flag cleared", data_o, 0);
        check("R7 re-armed", scan_en_o, 1);
        cs_n_i = 1'b0;
        wait_cyc(HALF);
        check("R7 discarded image gives invalid read", data_valid_o, 0);
        check("R8 data zero without request", data_o, 0);

        cur_req = "R8";
        offer(24'hFF_FF_FF);
        check("R8 scan disabled while select low", scan_en_o, 0);
        for (int i = 0; i < 4; i++) begin
            fall_edge();
            rise_sample();
            check("R8 blind bit", {sampled, data_valid_o}, 2'b00);
        end
        cs_n_i = 1'b1;
        wait_cyc(HALF);
        check("R2 strobe during select low ignored", data_o, 0);
        check("R8 no done after blind read", done_cnt, 2);

        cur_req = "R6";
        offer(24'h00_00_01);
        check("R6 accepts after re-arm", data_o, 1);
        wait_cyc(4);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule